// File: doc/BRIEF.md
# Translation Buffer Maintenance Registers

This block holds a small fully associative set of page translation entries and the register file that software uses to maintain them. Every change to the entries comes from a register write. Software first fills a staging register with a page table entry and an address-space register with the current process number. A commit write then builds a new entry from those staged values. Three control writes remove entries. One removes everything. One removes only the entries that are private to a process. One removes a single page of the current process.

A parameter selects one of two flavours. In the data flavour, writing the address register commits the entry. In the instruction flavour, writing the entry register commits, using the address written earlier, and the write-permission field of the stored entry is always zero. A combinational read port returns any slot's stored entry, packed into a 64-bit word. A second read port returns the maintenance registers. Two one-cycle error pulses report a malformed entry and an undefined register index.

Top module: `xlat_maint`

## Requirements
- R1: Register indices are: 0 entry staging (reads back the full written word), 1 address space (bits 6:0 kept, reads back zero-extended), 2 address (reads back the full written word), 3 flush-all and 4 flush-private (both always read zero), 5 flush-one (reads back the last written word). Every other index reads zero.
- R2: In the data flavour, a write to index 2 commits an entry. The entry's page number is written bits 42:13, its fields come from the staged entry register and its ASN is the address-space register. The entry is visible on the read port in the cycle after the write strobe.
- R3: In the instruction flavour, a write to index 0 commits an entry. Its fields come from the written word, its page number from the address register written before, its ASN from the address-space register, and its write-enable field is forced to 0.
- R4: Entry words use the same layout for input and readback. PPN is bits 58:32, read-enable bits 11:8, write-enable bits 15:12, fault-on-read bit 1, fault-on-write bit 2 and ASM bit 4. On readback the 7-bit ASN is ORed into bits 63:57, and all other readback bits are zero.
- R5: A commit whose entry has a nonzero granularity field (bits 6:5) inserts nothing. It raises errGh for exactly the following cycle.
- R6: A write to an index above 5 changes no entry and no register. It raises errBadSel for exactly the following cycle.
- R7: A write to index 3 invalidates every entry.
- R8: A write to index 4 invalidates exactly those entries whose ASM bit is 0.
- R9: A write to index 5 invalidates each valid entry whose page number equals written bits 42:13 and whose ASN equals the current address-space register.
- R10: Slot choice for a commit follows this priority. First, the lowest valid entry with the same page number whose ASN matches or whose ASM bit is set is overwritten. Otherwise the lowest invalid slot is used. Otherwise the victim pointer's slot is used, and only in that case the pointer advances by one, modulo the entry count.
- R11: After reset, all entries are invalid, all registers read zero, both error outputs are low and the victim pointer is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| wrSel | input | 4 | Register index for the write |
| wrData | input | 64 | Write data |
| regSel | input | 4 | Register index for readback |
| regData | output | 64 | Register readback |
| rdIdx | input | IDX_W (4) | Entry slot for readback |
| rdValid | output | 1 | Selected slot holds a valid entry |
| rdPte | output | 64 | Packed entry of the selected slot |
| errGh | output | 1 | Nonzero granularity field on a commit |
| errBadSel | output | 1 | Write to an undefined index |

## Verification
Two functions can fall in the same cycle here: hit detection against existing entries and victim replacement. A commit whose page and ASN match a resident entry while every slot is full must overwrite that entry and leave the victim pointer where it was. The stimulus draws pages from a pool only a little larger than the buffer, with only four ASNs, so full buffers and repeated pages meet often. After every write, the bench reads all slots and all registers and compares them with its own model of placement. A wrong pointer move shows up later as an eviction in the wrong slot.

// File: rtl/xlat_maint_pkg.sv
package xlat_maint_pkg;

  localparam int PPN_W = 27;
  localparam int PERM_W = 4;
  localparam int ASN_W = 7;
  localparam int GH_W = 2;
  localparam int WORD_W = 64;

  typedef enum logic [3:0] {
    SEL_PTE      = 4'd0,
    SEL_ASN      = 4'd1,
    SEL_TAG      = 4'd2,
    SEL_KILLALL  = 4'd3,
    SEL_KILLPROC = 4'd4,
    SEL_KILLONE  = 4'd5
  } regSelT;

  typedef struct packed {
    logic [PPN_W-1:0]  ppn;
    logic [PERM_W-1:0] rdEnable;
    logic [PERM_W-1:0] wrEnable;
    logic              faultRd;
    logic              faultWr;
    logic              spaceMatch;
  } pteT;

  typedef struct packed {
    logic              insert;
    logic              killAll;
    logic              killProc;
    logic              killOne;
    logic [WORD_W-1:0] va;
    pteT               pte;
    logic [ASN_W-1:0]  asn;
  } strobeT;

  function automatic pteT unpackPte(logic [WORD_W-1:0] w);
    pteT p;
    p.ppn        = w[32 +: PPN_W];
    p.rdEnable   = w[8 +: PERM_W];
    p.wrEnable   = w[12 +: PERM_W];
    p.faultRd    = w[1];
    p.faultWr    = w[2];
    p.spaceMatch = w[4];
    return p;
  endfunction

  function automatic logic [GH_W-1:0] ghOf(logic [WORD_W-1:0] w);
    return w[5 +: GH_W];
  endfunction

  function automatic logic [WORD_W-1:0] packPte(pteT p, logic [ASN_W-1:0] asn);
    logic [WORD_W-1:0] r;
    r = '0;
    r[32 +: PPN_W]  = p.ppn;
    r[8 +: PERM_W]  = p.rdEnable;
    r[12 +: PERM_W] = p.wrEnable;
    r[1]            = p.faultRd;
    r[2]            = p.faultWr;
    r[4]            = p.spaceMatch;
    r[WORD_W-ASN_W +: ASN_W] = r[WORD_W-ASN_W +: ASN_W] | asn;
    return r;
  endfunction

endpackage

// File: rtl/xlat_maint_ctrl.sv
module xlat_maint_ctrl
  import xlat_maint_pkg::*;
#(
  parameter bit IS_INSTR = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [3:0]        wrSel,
  input  logic [WORD_W-1:0] wrData,
  input  logic [3:0]        regSel,
  output logic [WORD_W-1:0] regData,
  output strobeT            strb,
  output logic              errGh,
  output logic              errBadSel
);

  logic [WORD_W-1:0] pteReg;
  logic [WORD_W-1:0] tagReg;
  logic [WORD_W-1:0] oneReg;
  logic [ASN_W-1:0]  asnReg;
  logic              ghBad;
  logic              selBad;

  always_comb begin
    strb   = '0;
    ghBad  = 1'b0;
    selBad = 1'b0;
    strb.asn = asnReg;
    strb.va  = tagReg;
    if (wrEn) begin
      case (wrSel)
        SEL_PTE: begin
          if (IS_INSTR) begin
            if (ghOf(wrData) != '0) begin
              ghBad = 1'b1;
            end else begin
              strb.insert = 1'b1;
              strb.pte = unpackPte(wrData);
              strb.pte.wrEnable = '0;
            end
          end
        end
        SEL_ASN: ;
        SEL_TAG: begin
          if (!IS_INSTR) begin
            if (ghOf(pteReg) != '0) begin
              ghBad = 1'b1;
            end else begin
              strb.insert = 1'b1;
              strb.va  = wrData;
              strb.pte = unpackPte(pteReg);
            end
          end
        end
        SEL_KILLALL:  strb.killAll  = 1'b1;
        SEL_KILLPROC: strb.killProc = 1'b1;
        SEL_KILLONE: begin
          strb.killOne = 1'b1;
          strb.va      = wrData;
        end
        default: selBad = 1'b1;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pteReg    <= '0;
      tagReg    <= '0;
      oneReg    <= '0;
      asnReg    <= '0;
      errGh     <= 1'b0;
      errBadSel <= 1'b0;
    end else begin
      errGh     <= ghBad;
      errBadSel <= selBad;
      if (wrEn) begin
        case (wrSel)
          SEL_PTE:     pteReg <= wrData;
          SEL_ASN:     asnReg <= wrData[ASN_W-1:0];
          SEL_TAG:     tagReg <= wrData;
          SEL_KILLONE: oneReg <= wrData;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (regSel)
      SEL_PTE:     regData = pteReg;
      SEL_ASN:     regData = WORD_W'(asnReg);
      SEL_TAG:     regData = tagReg;
      SEL_KILLONE: regData = oneReg;
      default:     regData = '0;
    endcase
  end

  // R6
  bad_sel_after_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    errBadSel |-> $past(wrEn) && ($past(wrSel) > 4'd5));

  // R5
  gh_after_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    errGh |-> $past(wrEn) && ($past(wrSel) == (IS_INSTR ? 4'd0 : 4'd2)));

  // R6
  bad_sel_keeps_regs_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && wrSel > 4'd5) |=> $stable(pteReg) && $stable(tagReg) && $stable(asnReg) && $stable(oneReg));

endmodule

// File: rtl/xlat_maint_array.sv
module xlat_maint_array
  import xlat_maint_pkg::*;
#(
  parameter int ENTRIES    = 16,
  parameter int PAGE_SHIFT = 13,
  parameter int VPN_W      = 30,
  parameter bit IS_INSTR   = 1'b0,
  localparam int IDX_W     = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strb,
  input  logic [IDX_W-1:0]  rdIdx,
  output logic              rdValid,
  output logic [WORD_W-1:0] rdPte
);

  logic [ENTRIES-1:0] validQ;
  logic [VPN_W-1:0]   tagQ [ENTRIES];
  pteT                pteQ [ENTRIES];
  logic [ASN_W-1:0]   asnQ [ENTRIES];
  logic [IDX_W-1:0]   ptrQ;

  logic [VPN_W-1:0]   newVpn;
  logic [ENTRIES-1:0] hitVec;
  logic [ENTRIES-1:0] oneVec;
  logic [ENTRIES-1:0] privVec;
  logic               hitAny;
  logic               freeAny;
  logic [IDX_W-1:0]   hitIdx;
  logic [IDX_W-1:0]   freeIdx;
  logic [IDX_W-1:0]   slot;
  logic               usePtr;

  assign newVpn = strb.va[PAGE_SHIFT +: VPN_W];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_match
    assign hitVec[g]  = validQ[g] && (tagQ[g] == newVpn) &&
                        ((asnQ[g] == strb.asn) || pteQ[g].spaceMatch);
    assign oneVec[g]  = validQ[g] && (tagQ[g] == newVpn) && (asnQ[g] == strb.asn);
    assign privVec[g] = !pteQ[g].spaceMatch;
  end

  always_comb begin
    hitAny  = 1'b0;
    freeAny = 1'b0;
    hitIdx  = '0;
    freeIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (hitVec[i]) begin
        hitAny = 1'b1;
        hitIdx = IDX_W'(i);
      end
      if (!validQ[i]) begin
        freeAny = 1'b1;
        freeIdx = IDX_W'(i);
      end
    end
    usePtr = !hitAny && !freeAny;
    slot   = hitAny ? hitIdx : (freeAny ? freeIdx : ptrQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      validQ <= '0;
      ptrQ   <= '0;
      for (int i = 0; i < ENTRIES; i++) begin
        tagQ[i] <= '0;
        pteQ[i] <= '0;
        asnQ[i] <= '0;
      end
    end else begin
      if (strb.killAll) begin
        validQ <= '0;
      end else if (strb.killProc) begin
        validQ <= validQ & ~privVec;
      end else if (strb.killOne) begin
        validQ <= validQ & ~oneVec;
      end else if (strb.insert) begin
        validQ[slot] <= 1'b1;
        tagQ[slot]   <= newVpn;
        pteQ[slot]   <= strb.pte;
        asnQ[slot]   <= strb.asn;
        if (usePtr) begin
          ptrQ <= (ptrQ == IDX_W'(ENTRIES - 1)) ? '0 : ptrQ + 1'b1;
        end
      end
    end
  end

  assign rdValid = validQ[rdIdx];
  assign rdPte   = packPte(pteQ[rdIdx], asnQ[rdIdx]);

  // R7
  kill_all_empties_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.killAll |=> validQ == '0);

  // R8
  kill_proc_keeps_global_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.killProc |=> (validQ & privVec) == '0 && (validQ == ($past(validQ) & ~privVec)));

  // R2
  insert_sets_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.insert |=> validQ != '0);

  // R6
  idle_keeps_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.insert || strb.killAll || strb.killProc || strb.killOne) |=> $stable(validQ));

  // R10
  ptr_moves_on_insert_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.insert |=> $stable(ptrQ));

  if (IS_INSTR) begin : g_instr
    for (genvar g = 0; g < ENTRIES; g++) begin : g_xwe
      // R3
      instr_wr_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
        pteQ[g].wrEnable == '0);
    end
  end

endmodule

// File: rtl/xlat_maint.sv
module xlat_maint
  import xlat_maint_pkg::*;
#(
  parameter int ENTRIES    = 16,
  parameter int PAGE_SHIFT = 13,
  parameter int VPN_W      = 30,
  parameter bit IS_INSTR   = 1'b0,
  localparam int IDX_W     = $clog2(ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [3:0]       wrSel,
  input  logic [63:0]      wrData,
  input  logic [3:0]       regSel,
  output logic [63:0]      regData,
  input  logic [IDX_W-1:0] rdIdx,
  output logic             rdValid,
  output logic [63:0]      rdPte,
  output logic             errGh,
  output logic             errBadSel
);

  strobeT strb;

  xlat_maint_ctrl #(
    .IS_INSTR (IS_INSTR)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .wrEn      (wrEn),
    .wrSel     (wrSel),
    .wrData    (wrData),
    .regSel    (regSel),
    .regData   (regData),
    .strb      (strb),
    .errGh     (errGh),
    .errBadSel (errBadSel)
  );

  xlat_maint_array #(
    .ENTRIES    (ENTRIES),
    .PAGE_SHIFT (PAGE_SHIFT),
    .VPN_W      (VPN_W),
    .IS_INSTR   (IS_INSTR)
  ) u_array (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .rdIdx   (rdIdx),
    .rdValid (rdValid),
    .rdPte   (rdPte)
  );

endmodule

// File: tb/xlat_maint_test.sv
`timescale 1ns/100ps
module xlat_maint_test;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic        rstN;
  logic        wrEn;
  logic [3:0]  wrSel;
  logic [63:0] wrData;
  logic [3:0]  regSel;
  logic [3:0]  rdIdx;
  logic [63:0] regData [2];
  logic        rdValid [2];
  logic [63:0] rdPte [2];
  logic        errGh [2];
  logic        errBadSel [2];

  xlat_maint #(.IS_INSTR(1'b0)) uut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .regSel(regSel), .regData(regData[0]), .rdIdx(rdIdx), .rdValid(rdValid[0]),
    .rdPte(rdPte[0]), .errGh(errGh[0]), .errBadSel(errBadSel[0]));

  xlat_maint #(.IS_INSTR(1'b1)) uutI (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrSel(wrSel), .wrData(wrData),
    .regSel(regSel), .regData(regData[1]), .rdIdx(rdIdx), .rdValid(rdValid[1]),
    .rdPte(rdPte[1]), .errGh(errGh[1]), .errBadSel(errBadSel[1]));

  int checks = 0;
  int fails = 0;

  bit        mV    [2][16];
  bit [29:0] mTagE [2][16];
  bit [63:0] mWord [2][16];
  bit [6:0]  mAsnE [2][16];
  bit        mAsm  [2][16];
  bit [63:0] mPteR [2];
  bit [63:0] mTagR [2];
  bit [63:0] mOneR [2];
  bit [6:0]  mAsnR [2];
  int        mPtr  [2];
  bit        eGh   [2];
  bit        eBad  [2];

  // R4: readback layout
  function automatic bit [63:0] packW(bit [63:0] d, bit [6:0] asn, bit noWr);
    bit [63:0] w;
    w = '0;
    w[58:32] = d[58:32];
    w[11:8]  = d[11:8];
    w[15:12] = noWr ? 4'h0 : d[15:12];
    w[1] = d[1];
    w[2] = d[2];
    w[4] = d[4];
    w[63:57] = w[63:57] | asn;
    return w;
  endfunction

  // R10 placement, R5 granularity error
  function automatic void mInsert(int m, bit [63:0] va, bit [63:0] pte);
    bit [29:0] vpn;
    int slot;
    if (pte[6:5] != 2'b00) begin
      eGh[m] = 1'b1;
      return;
    end
    vpn = va[42:13];
    slot = -1;
    for (int i = 0; i < 16; i++)
      if (slot < 0 && mV[m][i] && mTagE[m][i] == vpn && (mAsnE[m][i] == mAsnR[m] || mAsm[m][i]))
        slot = i;
    for (int i = 0; i < 16; i++)
      if (slot < 0 && !mV[m][i]) slot = i;
    if (slot < 0) begin
      slot = mPtr[m];
      mPtr[m] = (mPtr[m] + 1) % 16;
    end
    mV[m][slot]    = 1'b1;
    mTagE[m][slot] = vpn;
    mAsnE[m][slot] = mAsnR[m];
    mAsm[m][slot]  = pte[4];
    mWord[m][slot] = packW(pte, mAsnR[m], m == 1);
  endfunction

  function automatic void mWrite(int m, int sel, bit [63:0] d);
    eGh[m] = 1'b0;
    eBad[m] = 1'b0;
    case (sel)
      0: begin
        mPteR[m] = d;
        if (m == 1) mInsert(m, mTagR[m], d);          // R3
      end
      1: mAsnR[m] = d[6:0];
      2: begin
        mTagR[m] = d;
        if (m == 0) mInsert(m, d, mPteR[m]);          // R2
      end
      3: for (int i = 0; i < 16; i++) mV[m][i] = 1'b0; // R7
      4: for (int i = 0; i < 16; i++) if (!mAsm[m][i]) mV[m][i] = 1'b0; // R8
      5: begin                                        // R9
        mOneR[m] = d;
        for (int i = 0; i < 16; i++)
          if (mV[m][i] && mTagE[m][i] == d[42:13] && mAsnE[m][i] == mAsnR[m]) mV[m][i] = 1'b0;
      end
      default: eBad[m] = 1'b1;                        // R6
    endcase
  endfunction

  // R1
  function automatic bit [63:0] mReg(int m, int s);
    case (s)
      0: return mPteR[m];
      1: return 64'(mAsnR[m]);
      2: return mTagR[m];
      5: return mOneR[m];
      default: return 64'h0;
    endcase
  endfunction

  task automatic chk(string req, string what, bit [63:0] act, bit [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic sweep(string req);
    for (int i = 0; i < 16; i++) begin
      rdIdx = 4'(i);
      #1;
      for (int m = 0; m < 2; m++) begin
        chk(req, $sformatf("m%0d slot%0d valid", m, i), 64'(rdValid[m]), 64'(mV[m][i]));
        if (mV[m][i])
          chk(req, $sformatf("m%0d slot%0d entry", m, i), rdPte[m], mWord[m][i]);
      end
    end
    for (int s = 0; s < 8; s++) begin
      regSel = 4'(s);
      #1;
      for (int m = 0; m < 2; m++)
        chk("R1", $sformatf("m%0d reg%0d", m, s), regData[m], mReg(m, s));
    end
  endtask

  task automatic doWrite(int sel, bit [63:0] d, string req);
    @(negedge clk);
    wrEn = 1'b1;
    wrSel = 4'(sel);
    wrData = d;
    for (int m = 0; m < 2; m++) mWrite(m, sel, d);
    @(negedge clk);
    wrEn = 1'b0;
    for (int m = 0; m < 2; m++) begin
      chk("R5", $sformatf("m%0d errGh", m), 64'(errGh[m]), 64'(eGh[m]));
      chk("R6", $sformatf("m%0d errBadSel", m), 64'(errBadSel[m]), 64'(eBad[m]));
    end
    sweep(req);
  endtask

  function automatic bit [63:0] vaOf(int page);
    bit [63:0] v;
    v = {$urandom, $urandom};
    v[63:43] = '0;
    v[42:13] = 30'(page * 37 + 1);
    return v;
  endfunction

  function automatic bit [63:0] pteOf(bit asmBit, bit [1:0] gh);
    bit [63:0] p;
    p = {$urandom, $urandom};
    p[4] = asmBit;
    p[6:5] = gh;
    return p;
  endfunction

  initial begin
    for (int m = 0; m < 2; m++) begin
      mPteR[m] = '0; mTagR[m] = '0; mOneR[m] = '0; mAsnR[m] = '0; mPtr[m] = 0;
      eGh[m] = 1'b0; eBad[m] = 1'b0;
      for (int i = 0; i < 16; i++) begin
        mV[m][i] = 1'b0; mTagE[m][i] = '0; mWord[m][i] = '0; mAsnE[m][i] = '0; mAsm[m][i] = 1'b0;
      end
    end
    void'($urandom(32'd1234));
    rstN = 1'b0; wrEn = 1'b0; wrSel = '0; wrData = '0; regSel = '0; rdIdx = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      chk("R11", "errGh after reset", 64'(errGh[m]), 64'h0);
      chk("R11", "errBadSel after reset", 64'(errBadSel[m]), 64'h0);
    end
    sweep("R11");

    // R2 / R3 basic commit; R4 overlap of ASN with top PPN bits
    doWrite(1, 64'hFFFF_FFFF_FFFF_FF7F, "R1");
    doWrite(0, 64'h07FF_FFFF_0000_FF9E, "R3");
    doWrite(2, vaOf(3), "R2");
    doWrite(0, 64'h0000_0001_0000_5612, "R4");
    // R5: bad granularity on a commit
    doWrite(0, pteOf(1'b0, 2'b10), "R5");
    doWrite(2, vaOf(4), "R5");
    // R6: undefined index
    doWrite(9, 64'hDEAD_BEEF_0000_0001, "R6");
    doWrite(15, 64'h1, "R6");
    // R10: overfill with distinct pages to reach the victim pointer
    doWrite(1, 64'h2, "R1");
    for (int k = 0; k < 20; k++) begin
      doWrite(0, pteOf(k[0], 2'b00), "R10");
      doWrite(2, vaOf(k), "R10");
    end
    // R10: hit on a resident page while full, pointer must not move
    doWrite(2, vaOf(15), "R10");
    doWrite(2, vaOf(30), "R10");
    // R9, R8, R7
    doWrite(5, vaOf(17), "R9");
    doWrite(4, 64'hFFFF, "R8");
    doWrite(3, 64'h55, "R7");

    for (int n = 0; n < 500; n++) begin
      int r;
      int sel;
      bit [63:0] d;
      r = int'($urandom % 100);
      if (r < 25) begin
        sel = 0; d = pteOf(1'($urandom), ($urandom % 8 == 0) ? 2'(1 + $urandom % 3) : 2'b00);
      end else if (r < 35) begin
        sel = 1; d = {$urandom, $urandom}; d[6:0] = 7'($urandom % 4);
      end else if (r < 72) begin
        sel = 2; d = vaOf(int'($urandom % 22));
      end else if (r < 74) begin
        sel = 3; d = {$urandom, $urandom};
      end else if (r < 79) begin
        sel = 4; d = {$urandom, $urandom};
      end else if (r < 94) begin
        sel = 5; d = vaOf(int'($urandom % 22));
      end else begin
        sel = 6 + int'($urandom % 10); d = {$urandom, $urandom};
      end
      doWrite(sel, d, "R10");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule